// File: doc/BRIEF.md
# Nanosecond Timer with Alarm

The block is a memory-mapped time base that holds a free-running 64-bit count in nanoseconds. Every clock the count advances by a fixed, parameterised number of nanoseconds. A simple 32-bit register bus reaches all state: an address, a write strobe with write data, and a read strobe with a registered read-data return. Because the bus is 32 bits wide, the 64-bit count and the 64-bit alarm compare value are each split into a low word and a high word. The block guarantees that a 64-bit quantity is never seen or loaded half-updated.

Software arms a single alarm. To do so it writes the upper alarm word first and then the lower word. The lower-word write completes the compare value and arms the alarm. When an armed alarm's value is at or below the running count, the alarm disarms itself and sets a sticky pending flag. That flag drives a level interrupt output whenever interrupts are enabled. Software can cancel an armed alarm without raising the interrupt, and it acknowledges the interrupt by writing the interrupt-clear register.

Top module: `nst_timer`

## Requirements
- R1: After reset the count, the alarm value, the snapshot and the staging words are zero. The alarm is disarmed, interrupts are masked, `irq` is 0 and `bus_rdata` is 0.
- R2: The count grows by INC_NS on every clock that does not load it. A read of word 0 (byte offset 0x00) returns bits 31:0 of the count as it stood at the read edge.
- R3: A read of word 0 copies bits 63:32 of the count at that same edge into a snapshot. A read of word 1 (0x04) returns that snapshot and not the live count.
- R4: A write to word 1 goes only to a time staging register and leaves the count alone. A write to word 0 loads the count with {staging, write data}.
- R5: A write to word 3 (0x0C) stages the upper alarm word. A write to word 2 (0x08) loads the alarm with {alarm staging, write data} and arms it. Words 2 and 3 read back the low and high halves of the loaded alarm. Word 6 (0x18) reads 1 in bit 0 while the alarm is armed and 0 otherwise.
- R6: On an edge where the alarm is armed and alarm <= count (unsigned), the alarm disarms and the pending flag sets. Both take effect at that edge. A word 2 write on the same edge rearms instead.
- R7: A write to word 5 (0x14) with bit 0 = 1 disarms the alarm without setting the pending flag. The same write with bit 0 = 0 has no effect.
- R8: Bit 0 of a word 4 (0x10) write sets the interrupt enable, and word 4 reads it back in bit 0. `irq` equals pending AND enable. Pending stays set while interrupts are masked.
- R9: Any write to word 7 (0x1C) clears the pending flag. An expiry on the same edge keeps it set.
- R10: Read data is registered and appears the cycle after the read strobe. It holds between reads. Words 5 and 7 read as 0, and address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address; bits 4:2 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Level interrupt: pending and enabled |

## Verification
The hardest conditions to reach are alarm expiry at the exact edge where the count first equals the alarm, and expiry colliding with another bus action on the same edge: a rearm, a cancel or an interrupt clear. Random alarm values therefore sit within a few hundred nanoseconds of the modelled count, some below it and some above, so expiries fall among random bus traffic. A reference model tracks the count edge by edge, and `irq` is compared after every operation and every idle cycle. This pins the expiry to a single cycle. Directed cases add an alarm exactly two steps ahead, an alarm already in the past while masked, and a cancel with bit 0 clear and then set.

// File: rtl/nst_pkg.sv
package nst_pkg;
    typedef enum logic [2:0] {
        IDX_TLO  = 3'd0,
        IDX_THI  = 3'd1,
        IDX_ALO  = 3'd2,
        IDX_AHI  = 3'd3,
        IDX_IEN  = 3'd4,
        IDX_CLRA = 3'd5,
        IDX_STAT = 3'd6,
        IDX_CLRI = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic tlo;
        logic thi;
        logic alo;
        logic ahi;
        logic ien;
        logic clra;
        logic clri;
    } wstb_t;
endpackage

// File: rtl/nst_regif.sv
module nst_regif
    import nst_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [2*DATA_W-1:0]   count_i,
    input  logic [DATA_W-1:0]     snap_i,
    input  logic [2*DATA_W-1:0]   alarm_i,
    input  logic                  armed_i,
    input  logic                  ien_i,
    output wstb_t                 wstb_o,
    output logic                  rd_tlo_o,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam int IDX_LSB = 2;
    localparam int IDX_W   = 3;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rif_t;

    rif_t     r_d, r_q;
    reg_idx_e idx;

    assign idx = reg_idx_e'(addr_i[IDX_LSB +: IDX_W]);

    always_comb begin
        wstb_o      = '0;
        wstb_o.tlo  = wr_i && (idx == IDX_TLO);
        wstb_o.thi  = wr_i && (idx == IDX_THI);
        wstb_o.alo  = wr_i && (idx == IDX_ALO);
        wstb_o.ahi  = wr_i && (idx == IDX_AHI);
        wstb_o.ien  = wr_i && (idx == IDX_IEN);
        wstb_o.clra = wr_i && (idx == IDX_CLRA);
        wstb_o.clri = wr_i && (idx == IDX_CLRI);
        rd_tlo_o    = rd_i && (idx == IDX_TLO);
    end

    always_comb begin
        r_d = r_q;
        if (rd_i) begin
            unique case (idx)
                IDX_TLO:  r_d.rdata = count_i[DATA_W-1:0];
                IDX_THI:  r_d.rdata = snap_i;
                IDX_ALO:  r_d.rdata = alarm_i[DATA_W-1:0];
                IDX_AHI:  r_d.rdata = alarm_i[2*DATA_W-1:DATA_W];
                IDX_IEN:  r_d.rdata = {{(DATA_W-1){1'b0}}, ien_i};
                IDX_STAT: r_d.rdata = {{(DATA_W-1){1'b0}}, armed_i};
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata_o = r_q.rdata;

    // R10: without a read strobe the returned data holds
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
    // R10: at most one write target per cycle
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wstb_o));
endmodule

// File: rtl/nst_counter.sv
module nst_counter #(
    parameter int DATA_W = 32,
    parameter int INC_NS = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_lo_i,
    input  logic                  we_hi_i,
    input  logic                  rd_lo_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   count_o,
    output logic [DATA_W-1:0]     snap_o
);
    localparam int TW = 2 * DATA_W;
    localparam logic [TW-1:0] STEP = TW'(INC_NS);

    typedef struct packed {
        logic [TW-1:0]     count;
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] snap;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.count = c_q.count + STEP;
        if (we_hi_i) c_d.stage = wdata_i;
        if (we_lo_i) c_d.count = {c_q.stage, wdata_i};
        if (rd_lo_i) c_d.snap  = c_q.count[TW-1:DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count_o = c_q.count;
    assign snap_o  = c_q.snap;

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_lo_i |=> count_o == $past(count_o) + STEP);
    assert_hi_only_stages_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi_i |=> count_o[TW-1:DATA_W] == $past(count_o + STEP) >> DATA_W);
    assert_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i |=> snap_o == $past(count_o[TW-1:DATA_W]));
endmodule

// File: rtl/nst_alarm.sv
module nst_alarm #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_lo_i,
    input  logic                  we_hi_i,
    input  logic                  cancel_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [2*DATA_W-1:0]   count_i,
    output logic [2*DATA_W-1:0]   alarm_o,
    output logic                  armed_o,
    output logic                  fire_o
);
    localparam int TW = 2 * DATA_W;

    typedef struct packed {
        logic [TW-1:0]     alarm;
        logic [DATA_W-1:0] stage;
        logic              armed;
    } alm_t;

    alm_t a_d, a_q;
    logic due;

    assign due    = a_q.alarm <= count_i;
    assign fire_o = a_q.armed && due;

    always_comb begin
        a_d = a_q;
        if (we_hi_i) a_d.stage = wdata_i;
        if (we_lo_i) begin
            a_d.alarm = {a_q.stage, wdata_i};
            a_d.armed = 1'b1;
        end else if (fire_o || cancel_i) begin
            a_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign alarm_o = a_q.alarm;
    assign armed_o = a_q.armed;

    assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo_i |=> armed_o);
    assert_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !we_lo_i) |=> !armed_o);
    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i && !we_lo_i) |=> !armed_o);
endmodule

// File: rtl/nst_irq.sv
module nst_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic we_ien_i,
    input  logic ien_bit_i,
    input  logic clr_i,
    input  logic fire_i,
    output logic ien_o,
    output logic irq_o
);
    typedef struct packed {
        logic ien;
        logic pend;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d = i_q;
        if (we_ien_i) i_d.ien = ien_bit_i;
        if (fire_i)     i_d.pend = 1'b1;
        else if (clr_i) i_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign ien_o = i_q.ien;
    assign irq_o = i_q.pend && i_q.ien;

    assert_pend_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i_q.pend) |-> $past(fire_i));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire_i) |=> !irq_o);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_q.pend && !clr_i) |=> i_q.pend);
endmodule

// File: rtl/nst_timer.sv
module nst_timer
    import nst_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int INC_NS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int TW = 2 * DATA_W;

    wstb_t             wstb;
    logic              rd_tlo;
    logic [TW-1:0]     count;
    logic [DATA_W-1:0] snap;
    logic [TW-1:0]     alarm;
    logic              armed;
    logic              fire;
    logic              ien;

    nst_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .count_i  (count),
        .snap_i   (snap),
        .alarm_i  (alarm),
        .armed_i  (armed),
        .ien_i    (ien),
        .wstb_o   (wstb),
        .rd_tlo_o (rd_tlo),
        .rdata_o  (bus_rdata)
    );

    nst_counter #(.DATA_W(DATA_W), .INC_NS(INC_NS)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_lo_i (wstb.tlo),
        .we_hi_i (wstb.thi),
        .rd_lo_i (rd_tlo),
        .wdata_i (bus_wdata),
        .count_o (count),
        .snap_o  (snap)
    );

    nst_alarm #(.DATA_W(DATA_W)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_lo_i  (wstb.alo),
        .we_hi_i  (wstb.ahi),
        .cancel_i (wstb.clra && bus_wdata[0]),
        .wdata_i  (bus_wdata),
        .count_i  (count),
        .alarm_o  (alarm),
        .armed_o  (armed),
        .fire_o   (fire)
    );

    nst_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_ien_i  (wstb.ien),
        .ien_bit_i (bus_wdata[0]),
        .clr_i     (wstb.clri),
        .fire_i    (fire),
        .ien_o     (ien),
        .irq_o     (irq)
    );
endmodule

// File: tb/tb_nst_timer.sv
module tb_nst_timer;
    localparam int INC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    nst_timer #(.ADDR_W(5), .DATA_W(32), .INC_NS(INC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [63:0] m_count, m_alarm;
    logic [31:0] m_tstage, m_astage, m_snap, m_rdata;
    logic        m_armed, m_pend, m_ien, m_fire;
    logic [63:0] m_next;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_count = '0; m_alarm = '0; m_tstage = '0; m_astage = '0;
            m_snap = '0; m_rdata = '0; m_armed = 0; m_pend = 0; m_ien = 0;
        end else begin
            m_fire = m_armed && (m_alarm <= m_count);
            if (bus_rd) begin
                case (bus_addr[4:2])
                    3'd0: m_rdata = m_count[31:0];
                    3'd1: m_rdata = m_snap;
                    3'd2: m_rdata = m_alarm[31:0];
                    3'd3: m_rdata = m_alarm[63:32];
                    3'd4: m_rdata = {31'd0, m_ien};
                    3'd6: m_rdata = {31'd0, m_armed};
                    default: m_rdata = '0;
                endcase
                if (bus_addr[4:2] == 3'd0) m_snap = m_count[63:32];
            end
            m_next = m_count + INC;
            if (bus_wr && bus_addr[4:2] == 3'd0) m_next = {m_tstage, bus_wdata};
            if (bus_wr && bus_addr[4:2] == 3'd1) m_tstage = bus_wdata;
            if (bus_wr && bus_addr[4:2] == 3'd3) m_astage = bus_wdata;
            if (bus_wr && bus_addr[4:2] == 3'd2) begin
                m_alarm = {m_astage, bus_wdata};
                m_armed = 1;
            end else if (m_fire) m_armed = 0;
            else if (bus_wr && bus_addr[4:2] == 3'd5 && bus_wdata[0]) m_armed = 0;
            if (m_fire) m_pend = 1;
            else if (bus_wr && bus_addr[4:2] == 3'd7) m_pend = 0;
            if (bus_wr && bus_addr[4:2] == 3'd4) m_ien = bus_wdata[0];
            m_count = m_next;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        bus_addr = 5'(idx * 4); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 irq", {63'd0, irq}, {63'd0, m_pend & m_ien});
    endtask

    task automatic rd(input int idx, input string req, output logic [31:0] v);
        bus_addr = 5'(idx * 4) | 5'($urandom % 4); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, {32'd0, bus_rdata}, {32'd0, m_rdata});
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R6 irq timing", {63'd0, irq}, {63'd0, m_pend & m_ien});
        end
    endtask

    function automatic string tag_of(input int idx);
        case (idx)
            0: return "R2 time low";
            1: return "R3 snapshot";
            2, 3, 6: return "R5 alarm/status";
            4: return "R8 enable";
            default: return "R10 zero word";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {63'd0, irq}, 64'd0);
        chk("R1 rdata", {32'd0, bus_rdata}, 64'd0);
        rd(6, "R1 status", v); chk("R1 status", {32'd0, v}, 64'd0);
        rd(4, "R1 enable", v); chk("R1 enable", {32'd0, v}, 64'd0);
        rd(1, "R1 snapshot", v); chk("R1 snapshot", {32'd0, v}, 64'd0);
        rd(2, "R1 alarm", v); chk("R1 alarm", {32'd0, v}, 64'd0);

        // R4 staging then load; R2 stepping; R3 snapshot
        wr(1, 32'd5);
        rd(0, "R4 staged high untouched", v);
        wr(0, 32'd100);
        rd(0, "R4 loaded low", v); chk("R4 load", {32'd0, v}, 64'd100);
        idle(3);
        rd(0, "R2 step", v); chk("R2 step", {32'd0, v}, 64'(100 + 4 * INC));
        rd(1, "R3 snap", v); chk("R3 snap", {32'd0, v}, 64'd5);
        wr(1, 32'd9); wr(0, 32'd0);
        rd(1, "R3 not live", v); chk("R3 not live", {32'd0, v}, 64'd5);

        // R5/R6 alarm exactly two steps ahead of the count
        wr(4, 32'd1);
        wr(1, 32'd0); wr(3, 32'd0);
        wr(0, 32'd1000);
        wr(2, 32'(1000 + 2 * INC));
        rd(6, "R5 armed", v); chk("R5 armed", {32'd0, v}, 64'd1);
        idle(2);
        chk("R6 irq raised", {63'd0, irq}, 64'd1);
        rd(6, "R6 disarmed", v); chk("R6 disarmed", {32'd0, v}, 64'd0);
        rd(2, "R5 alarm low", v); chk("R5 alarm low", {32'd0, v}, 64'(1000 + 2 * INC));
        wr(7, 32'd0);
        chk("R9 cleared", {63'd0, irq}, 64'd0);

        // R7 cancel
        wr(3, 32'd1); wr(2, 32'd0);
        wr(5, 32'd0);
        rd(6, "R7 bit0 clear no effect", v); chk("R7 no effect", {32'd0, v}, 64'd1);
        wr(5, 32'd1);
        rd(6, "R7 cancelled", v); chk("R7 cancelled", {32'd0, v}, 64'd0);
        idle(4);
        chk("R7 no irq", {63'd0, irq}, 64'd0);

        // R8 pending while masked, alarm already past
        wr(4, 32'd0);
        wr(3, 32'd0); wr(2, 32'd1);
        idle(2);
        chk("R8 masked", {63'd0, irq}, 64'd0);
        wr(4, 32'd1);
        chk("R8 unmasked", {63'd0, irq}, 64'd1);
        wr(7, 32'hFFFF_FFFF);
        chk("R9 clear", {63'd0, irq}, 64'd0);
        rd(5, "R10 clear-alarm reads 0", v); chk("R10 zero", {32'd0, v}, 64'd0);
        rd(7, "R10 clear-irq reads 0", v); chk("R10 zero", {32'd0, v}, 64'd0);

        // random traffic with alarms near the count
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = int'($urandom % 12);
            t = m_count;
            case (op)
                0:  wr(1, $urandom % 3);
                1:  wr(0, $urandom);
                2:  wr(3, t[63:32]);
                3:  wr(2, t[31:0] + 32'($urandom % 600) - 32'd100);
                4:  wr(4, $urandom % 2);
                5:  wr(5, $urandom % 2);
                6:  wr(7, $urandom);
                11: idle(int'($urandom % 6));
                default: begin
                    int idx;
                    idx = int'($urandom % 8);
                    rd(idx, tag_of(idx), v);
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule